// File: doc/BRIEF.md
# Configuration Request Redirect Ring

This block sits at a host-facing edge of a shared-I/O switch and keeps host configuration cycles (for example, the reads and writes of a boot-time bus scan) from ever reaching a physical device. Each accepted request is packed into a fixed-format descriptor. The descriptor is written into a 16-entry ring that lives in memory owned by the management processor. The block then bumps its producer pointer and pulses an interrupt so that software knows there is work. Software advances its consumer pointer as it drains entries.

Every descriptor carries the ingress host port and a small outstanding-slot tag. The slot remembers the host's own request tag. Software answers with a response naming that slot, plus a status and read data. The block turns the response into a one-cycle completion that carries the original host port and host tag. Reads and writes are both answered this way.

A small state machine controls the request side. It has three states:
- `S_IDLE`: room exists and the block is ready.
- `S_STALL`: the ring is full or every slot is busy, so ready is low.
- `S_WRITE`: the descriptor write cycle.

The transitions are:
- IDLE→WRITE and STALL→WRITE on an accepted request.
- IDLE→STALL when room disappears.
- STALL→IDLE when room returns.
- WRITE→IDLE unconditionally.

Top module: `cfg_redirect_ring`

## Requirements
- R1: While reset is held, `prod_ptr` is 0 and `ring_we`, `ring_irq`, `cpl_valid` and `rsp_bad` are all 0.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both high) produces exactly one `ring_we` cycle, in the cycle that follows. In that cycle `ring_addr` equals the current `prod_ptr`, and `ring_wdata` = {wdata[31:0], be[3:0], reg[9:0], target_id[15:0], rw, slot, port}, with port in the least significant bits. `req_ready` is low during the write cycle.
- R3: In the cycle after a descriptor write, `prod_ptr` has advanced by exactly one and `ring_irq` is high for that single cycle.
- R4: The ring is full when `prod_ptr`+1 (mod 16) equals `cons_ptr`. While it is full, `req_ready` stays low and the pending request is held, not lost. It is accepted once `cons_ptr` moves.
- R5: At most 4 requests are outstanding. With all four slots busy, `req_ready` is low until a response frees a slot.
- R6: A new request takes the lowest-numbered free slot, and that number appears in the descriptor's slot field.
- R7: A response whose `rsp_tag` names a busy slot yields, one cycle later, a single-cycle `cpl_valid` carrying the original host port, the original host tag, `rsp_status` and `rsp_rdata`. The slot becomes free.
- R8: A response whose `rsp_tag` names a free slot raises `rsp_bad` for one cycle, produces no completion, and leaves slot state unchanged.
- R9: Configuration writes receive a completion exactly as reads do.
- R10: `prod_ptr` wraps from 15 to 0, and descriptors continue at ring address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host configuration request present |
| req_ready | output | 1 | Request accepted at this edge when high with req_valid |
| req_port | input | PORT_W | Ingress host port |
| req_htag | input | HTAG_W | Host's own request tag |
| req_rw | input | 1 | 1 = write, 0 = read |
| req_tid | input | 16 | Target bus/device/function ID |
| req_reg | input | 10 | Register number |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| ring_we | output | 1 | Descriptor write strobe |
| ring_addr | output | RING_AW | Ring entry index |
| ring_wdata | output | DESC_W | Descriptor |
| prod_ptr | output | RING_AW | Producer pointer |
| cons_ptr | input | RING_AW | Consumer pointer from software |
| ring_irq | output | 1 | Pulse on producer advance |
| rsp_valid | input | 1 | Software response present |
| rsp_tag | input | SLOT_W | Slot being answered |
| rsp_status | input | 3 | Completion status |
| rsp_rdata | input | 32 | Read data |
| cpl_valid | output | 1 | Completion pulse to host |
| cpl_port | output | PORT_W | Host port of the completion |
| cpl_htag | output | HTAG_W | Host tag of the completion |
| cpl_status | output | 3 | Completion status |
| cpl_rdata | output | 32 | Completion data |
| rsp_bad | output | 1 | Response named a free slot |

## Verification
The bench builds the block with its defaults: four slots, a 16-entry ring, 2-bit ports and 8-bit host tags. With only sixteen entries, a few dozen requests drive the ring into full, hold a request there, and then wrap the producer. Four slots are few enough that the all-busy stall is reached within a handful of requests, and that the lowest-free choice can be observed after an out-of-order response.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;
    localparam int DATA_W = 32;
    localparam int TID_W  = 16;
    localparam int REG_W  = 10;
    localparam int BE_W   = 4;
    localparam int ST_W   = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WRITE = 2'd1,
        S_STALL = 2'd2
    } fsm_t;
endpackage

// File: rtl/cfgr_slot_table.sv
module cfgr_slot_table #(
    parameter int SLOTS  = 4,
    parameter int PORT_W = 2,
    parameter int HTAG_W = 8,
    localparam int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [PORT_W-1:0] alloc_port,
    input  logic [HTAG_W-1:0] alloc_htag,
    output logic [SLOT_W-1:0] alloc_idx,
    output logic              any_free,
    input  logic              lk_valid,
    input  logic [SLOT_W-1:0] lk_idx,
    output logic              lk_hit,
    output logic [PORT_W-1:0] lk_port,
    output logic [HTAG_W-1:0] lk_htag
);
    logic [SLOTS-1:0]  busy_q;
    logic [PORT_W-1:0] port_q [SLOTS];
    logic [HTAG_W-1:0] htag_q [SLOTS];

    // lowest free slot wins
    always_comb begin
        alloc_idx = '0;
        any_free  = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!busy_q[i]) begin
                alloc_idx = SLOT_W'(i);
                any_free  = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g] <= 1'b0;
                port_q[g] <= '0;
                htag_q[g] <= '0;
            end else if (alloc_en && alloc_idx == SLOT_W'(g)) begin
                busy_q[g] <= 1'b1;
                port_q[g] <= alloc_port;
                htag_q[g] <= alloc_htag;
            end else if (lk_valid && lk_hit && lk_idx == SLOT_W'(g)) begin
                busy_q[g] <= 1'b0;
            end
        end
    end

    assign lk_hit  = busy_q[lk_idx];
    assign lk_port = port_q[lk_idx];
    assign lk_htag = htag_q[lk_idx];
endmodule

// File: rtl/cfgr_ring_ptr.sv
module cfgr_ring_ptr #(
    parameter int RING_AW = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               advance,
    input  logic [RING_AW-1:0] cons_ptr,
    output logic [RING_AW-1:0] prod_ptr,
    output logic               has_room
);
    localparam logic [RING_AW-1:0] ONE = RING_AW'(1);

    logic [RING_AW-1:0] prod_q;
    logic [RING_AW-1:0] prod_nxt;

    assign prod_nxt = prod_q + ONE;
    assign has_room = (prod_nxt != cons_ptr);
    assign prod_ptr = prod_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prod_q <= '0;
        else if (advance) prod_q <= prod_nxt;
    end
endmodule

// File: rtl/cfg_redirect_ring.sv
module cfg_redirect_ring
    import cfgr_pkg::*;
#(
    parameter int PORT_W  = 2,
    parameter int HTAG_W  = 8,
    parameter int RING_AW = 4,
    parameter int SLOTS   = 4,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int DESC_W = DATA_W + BE_W + REG_W + TID_W + 1 + SLOT_W + PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PORT_W-1:0]  req_port,
    input  logic [HTAG_W-1:0]  req_htag,
    input  logic               req_rw,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [REG_W-1:0]   req_reg,
    input  logic [BE_W-1:0]    req_be,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               ring_we,
    output logic [RING_AW-1:0] ring_addr,
    output logic [DESC_W-1:0]  ring_wdata,
    output logic [RING_AW-1:0] prod_ptr,
    input  logic [RING_AW-1:0] cons_ptr,
    output logic               ring_irq,
    input  logic               rsp_valid,
    input  logic [SLOT_W-1:0]  rsp_tag,
    input  logic [ST_W-1:0]    rsp_status,
    input  logic [DATA_W-1:0]  rsp_rdata,
    output logic               cpl_valid,
    output logic [PORT_W-1:0]  cpl_port,
    output logic [HTAG_W-1:0]  cpl_htag,
    output logic [ST_W-1:0]    cpl_status,
    output logic [DATA_W-1:0]  cpl_rdata,
    output logic               rsp_bad
);
    fsm_t state_q, state_d;

    logic              has_room, any_free, can_accept, accept, advance;
    logic [SLOT_W-1:0] alloc_idx;
    logic              lk_hit;
    logic [PORT_W-1:0] lk_port;
    logic [HTAG_W-1:0] lk_htag;
    logic [DESC_W-1:0] desc_q;
    logic              irq_q;

    cfgr_slot_table #(.SLOTS(SLOTS), .PORT_W(PORT_W), .HTAG_W(HTAG_W)) u_slots (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(accept), .alloc_port(req_port), .alloc_htag(req_htag),
        .alloc_idx(alloc_idx), .any_free(any_free),
        .lk_valid(rsp_valid), .lk_idx(rsp_tag),
        .lk_hit(lk_hit), .lk_port(lk_port), .lk_htag(lk_htag)
    );

    cfgr_ring_ptr #(.RING_AW(RING_AW)) u_ptr (
        .clk(clk), .rst_n(rst_n), .advance(advance),
        .cons_ptr(cons_ptr), .prod_ptr(prod_ptr), .has_room(has_room)
    );

    assign can_accept = has_room && any_free;
    assign accept     = req_valid && req_ready;
    assign advance    = (state_q == S_WRITE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (accept)           state_d = S_WRITE;
                else if (!can_accept) state_d = S_STALL;
            end
            S_STALL: begin
                if (accept)          state_d = S_WRITE;
                else if (can_accept) state_d = S_IDLE;
            end
            S_WRITE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // outputs of the request side
    always_comb begin
        req_ready  = (state_q != S_WRITE) && can_accept;
        ring_we    = (state_q == S_WRITE);
        ring_addr  = prod_ptr;
        ring_wdata = desc_q;
        ring_irq   = irq_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= advance;
            if (accept)
                desc_q <= {req_wdata, req_be, req_reg, req_tid, req_rw, alloc_idx, req_port};
        end
    end

    // response to completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpl_valid  <= 1'b0;
            rsp_bad    <= 1'b0;
            cpl_port   <= '0;
            cpl_htag   <= '0;
            cpl_status <= '0;
            cpl_rdata  <= '0;
        end else begin
            cpl_valid <= rsp_valid && lk_hit;
            rsp_bad   <= rsp_valid && !lk_hit;
            if (rsp_valid && lk_hit) begin
                cpl_port   <= lk_port;
                cpl_htag   <= lk_htag;
                cpl_status <= rsp_status;
                cpl_rdata  <= rsp_rdata;
            end
        end
    end
endmodule

// File: rtl/cfgr_redirect_chk.sv
module cfgr_redirect_chk #(
    parameter int RING_AW = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               ring_we,
    input logic [RING_AW-1:0] prod_ptr,
    input logic [RING_AW-1:0] cons_ptr,
    input logic               ring_irq,
    input logic               rsp_valid,
    input logic               cpl_valid,
    input logic               rsp_bad
);
    localparam logic [RING_AW-1:0] ONE = RING_AW'(1);
    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ring_we |-> (RING_AW'(prod_ptr + ONE) != cons_ptr));

    p_ready_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (RING_AW'(prod_ptr + ONE) == cons_ptr) |-> !req_ready);

    p_irq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ring_irq) |-> (prod_ptr == RING_AW'($past(prod_ptr) + ONE)));

    p_single_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ring_we |=> !ring_we);

    p_busy_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ring_we |-> !req_ready);

    p_cpl_or_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl_valid && rsp_bad));

    p_rsp_answered_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(rsp_valid)) |-> (cpl_valid || rsp_bad));
endmodule

bind cfg_redirect_ring cfgr_redirect_chk #(.RING_AW(RING_AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ring_we(ring_we),
    .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .ring_irq(ring_irq),
    .rsp_valid(rsp_valid), .cpl_valid(cpl_valid), .rsp_bad(rsp_bad)
);

// File: tb/cfg_redirect_ring_tb_top.sv
module cfg_redirect_ring_tb_top;
    localparam int PORT_W = 2, HTAG_W = 8, RING_AW = 4, SLOTS = 4, SLOT_W = 2;
    localparam int DEPTH = 16;
    localparam int DESC_W = 32 + 4 + 10 + 16 + 1 + SLOT_W + PORT_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_rw = 0;
    logic [PORT_W-1:0] req_port = '0;
    logic [HTAG_W-1:0] req_htag = '0;
    logic [15:0] req_tid = '0;
    logic [9:0]  req_reg = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic req_ready, ring_we, ring_irq, cpl_valid, rsp_bad;
    logic [RING_AW-1:0] ring_addr, prod_ptr;
    logic [RING_AW-1:0] cons_ptr = '0;
    logic [DESC_W-1:0] ring_wdata;
    logic rsp_valid = 0;
    logic [SLOT_W-1:0] rsp_tag = '0;
    logic [2:0] rsp_status = '0;
    logic [31:0] rsp_rdata = '0;
    logic [PORT_W-1:0] cpl_port;
    logic [HTAG_W-1:0] cpl_htag;
    logic [2:0] cpl_status;
    logic [31:0] cpl_rdata;

    cfg_redirect_ring #(.PORT_W(PORT_W), .HTAG_W(HTAG_W), .RING_AW(RING_AW), .SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_port(req_port), .req_htag(req_htag), .req_rw(req_rw), .req_tid(req_tid),
        .req_reg(req_reg), .req_be(req_be), .req_wdata(req_wdata),
        .ring_we(ring_we), .ring_addr(ring_addr), .ring_wdata(ring_wdata),
        .prod_ptr(prod_ptr), .cons_ptr(cons_ptr), .ring_irq(ring_irq),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .cpl_valid(cpl_valid), .cpl_port(cpl_port), .cpl_htag(cpl_htag),
        .cpl_status(cpl_status), .cpl_rdata(cpl_rdata), .rsp_bad(rsp_bad)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_prod = 0, m_phase = 0, m_wraps = 0;
    bit m_irq = 0, m_cpl_v = 0, m_bad = 0, m_crw = 0;
    bit m_busy [SLOTS];
    int m_port [SLOTS];
    int m_htag [SLOTS];
    bit m_rw   [SLOTS];
    logic [DESC_W-1:0] m_desc = '0;
    int m_cport = 0, m_ctag = 0, m_cst = 0, m_lastslot = 0;
    logic [31:0] m_crd = '0;

    function automatic bit m_free();
        for (int i = 0; i < SLOTS; i++) if (!m_busy[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_ready();
        return (m_phase == 0) && m_free() && (((m_prod + 1) % DEPTH) != int'(cons_ptr));
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prod = 0; m_phase = 0; m_irq = 0; m_cpl_v = 0; m_bad = 0; m_wraps = 0;
            for (int i = 0; i < SLOTS; i++) m_busy[i] = 0;
        end else begin
            bit old_busy [SLOTS];
            bit acc;
            for (int i = 0; i < SLOTS; i++) old_busy[i] = m_busy[i];
            acc = req_valid && m_ready();
            m_irq = (m_phase == 1);
            if (m_phase == 1) begin
                m_prod = (m_prod + 1) % DEPTH;
                if (m_prod == 0) m_wraps++;
            end
            m_phase = 0;
            if (acc) begin
                int s;
                s = 0;
                while (old_busy[s]) s++;
                m_busy[s] = 1; m_port[s] = int'(req_port); m_htag[s] = int'(req_htag);
                m_rw[s] = req_rw; m_lastslot = s;
                m_desc = {req_wdata, req_be, req_reg, req_tid, req_rw, SLOT_W'(s), req_port};
                m_phase = 1;
            end
            m_cpl_v = 0; m_bad = 0;
            if (rsp_valid) begin
                if (old_busy[rsp_tag]) begin
                    m_cpl_v = 1; m_cport = m_port[rsp_tag]; m_ctag = m_htag[rsp_tag];
                    m_cst = int'(rsp_status); m_crd = rsp_rdata; m_crw = m_rw[rsp_tag];
                    m_busy[rsp_tag] = 0;
                end else m_bad = 1;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(m_free() ? "R4 ready" : "R5 ready", 128'(req_ready), 128'(m_ready()));
            chk("R2 write strobe", 128'(ring_we), 128'(m_phase == 1));
            if (m_phase == 1) begin
                chk("R2 ring address", 128'(ring_addr), 128'(m_prod));
                chk("R2 descriptor", 128'(ring_wdata), 128'(m_desc));
                chk("R6 slot field", 128'(ring_wdata[PORT_W +: SLOT_W]), 128'(m_lastslot));
            end
            chk(m_wraps > 0 ? "R10 producer" : "R3 producer", 128'(prod_ptr), 128'(m_prod));
            chk("R3 irq", 128'(ring_irq), 128'(m_irq));
            chk("R7 completion valid", 128'(cpl_valid), 128'(m_cpl_v));
            if (m_cpl_v) begin
                chk(m_crw ? "R9 cpl port" : "R7 cpl port", 128'(cpl_port), 128'(m_cport));
                chk(m_crw ? "R9 cpl tag" : "R7 cpl tag", 128'(cpl_htag), 128'(m_ctag));
                chk(m_crw ? "R9 cpl status" : "R7 cpl status", 128'(cpl_status), 128'(m_cst));
                chk(m_crw ? "R9 cpl data" : "R7 cpl data", 128'(cpl_rdata), 128'(m_crd));
            end
            chk("R8 bad tag flag", 128'(rsp_bad), 128'(m_bad));
        end
    end

    task automatic send(int port, int ht, bit rw, int tid, int rg, int be, logic [31:0] wd);
        int guard;
        @(negedge clk);
        req_valid = 1; req_port = PORT_W'(port); req_htag = HTAG_W'(ht); req_rw = rw;
        req_tid = 16'(tid); req_reg = 10'(rg); req_be = 4'(be); req_wdata = wd;
        #1;
        guard = 0;
        while (!req_ready && guard < 5000) begin
            @(negedge clk); #1; guard++;
        end
        @(posedge clk); #1;
        req_valid = 0;
    endtask

    task automatic respond(int slot, int st, logic [31:0] rd);
        @(negedge clk);
        rsp_valid = 1; rsp_tag = SLOT_W'(slot); rsp_status = 3'(st); rsp_rdata = rd;
        @(posedge clk); #1;
        rsp_valid = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R1 reset producer", 128'(prod_ptr), 128'(0));
        chk("R1 reset write", 128'(ring_we), 128'(0));
        chk("R1 reset irq", 128'(ring_irq), 128'(0));
        chk("R1 reset cpl", 128'(cpl_valid), 128'(0));
        chk("R1 reset bad", 128'(rsp_bad), 128'(0));
        @(negedge clk); rst_n = 1;

        // read then write, answered out of order
        send(1, 8'h11, 0, 16'h0100, 10'h004, 4'hf, 32'h0);
        send(2, 8'h22, 1, 16'h0208, 10'h3ff, 4'h3, 32'hdeadbeef);
        respond(1, 1, 32'h0);
        respond(0, 0, 32'h12345678);
        // unknown slot
        respond(3, 2, 32'h55);
        repeat (2) @(negedge clk);

        // fill every slot, fifth waits for a response
        for (int i = 0; i < 4; i++) send(i, 8'h40 + i, i[0], 16'h1000 + i, i * 3, 4'h1 << i, 32'h100 + i);
        fork
            send(3, 8'h77, 0, 16'h2222, 10'h010, 4'hf, 32'h0);
            begin repeat (8) @(negedge clk); respond(2, 0, 32'haaaa5555); end
        join
        respond(0, 0, 32'h1); respond(1, 3, 32'h2); respond(3, 0, 32'h3); respond(2, 0, 32'h4);
        respond(2, 0, 32'h4);

        // run up to a full ring, consumer parked at 0
        for (int i = 0; i < 8; i++) begin
            send(i % 4, 8'h80 + i, 1, 16'h3000 + i, 10'h020 + i, 4'hc, 32'hc0de0000 + i);
            respond(0, 0, 32'h9000 + i);
        end
        fork
            send(0, 8'hee, 0, 16'h4444, 10'h044, 4'hf, 32'h0);
            begin repeat (10) @(negedge clk); cons_ptr = 4'd8; end
        join
        respond(0, 0, 32'hfeedf00d);

        // after wrap
        for (int i = 0; i < 3; i++) send(i, 8'hc0 + i, 0, 16'h5000 + i, 10'h100, 4'hf, 32'h0);
        respond(1, 0, 32'h11); respond(0, 0, 32'h22); respond(2, 0, 32'h33);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule